// File: doc/BRIEF.md
# Trigger Delay and Pattern Sequencer

This block drives the single serial trigger line of a front-end readout chip. It takes a hardware trigger, assumed already synchronous to the clock, and a software trigger strobe. It turns them into a bit stream in one of three ways. In delay mode the trigger stream runs through a shift register whose length is set from 1 to 256 cycles, so several triggers can be in flight at once. In pattern mode a trigger starts playback of up to four stored 256-bit sequences. The enabled sequences are played out together and ORed onto the line. In transparent mode the raw hardware trigger input is forwarded unchanged.

The four sequences reset to useful defaults: a soft-reset command, a calibration request with a second request later in the sequence, and two single-trigger sequences. Software can overwrite the sequences one 32-bit word at a time. When a pattern playback starts, a one-cycle hold strobe tells the ADC to expect data. The strobe is suppressed when the only enabled sequences are the soft-reset and calibration ones, because those produce no front-end output.

Top module: `trig_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, trig_out and hold_out are 0 (in pattern or delay mode with no trigger).
- R2: In delay mode (mode 00), with delay_len_m1 = L-1 held steady, trig_out in cycle c+L equals (hw_trig | sw_trig) in cycle c, for L from 1 to 256.
- R3: In delay mode, any pattern of triggers, including back-to-back ones, leaves the delay line unchanged apart from the shift, so many triggers can be in flight at once.
- R4: A change of delay_len_m1 clears the delay line at the next clock edge; no trigger that entered before the change ever appears at the output.
- R5: In pattern mode (mode 01), a trigger sampled at a clock edge starts playback at that edge. For k = 0..255 the output in the k-th cycle after it is the OR over the enabled sequences of bit 255-k (MSB first). pat_en is captured at the start. After the 256 bits, trig_out returns to 0.
- R6: A trigger that arrives while a playback is running (the 255 edges after the start edge) is ignored: the stream continues unchanged and no hold is issued.
- R7: hold_out is raised for a playback exactly when sequence 2 or 3 is enabled (pat_en[2] | pat_en[3]); sequences 0 and 1 alone never raise it.
- R8: hold_out is a one-cycle pulse in the same cycle as the first output bit of the playback.
- R9: In transparent mode (mode 10 or 11), trig_out equals hw_trig in the same cycle, combinationally.
- R10: A write with wr_en high sets bits [32w+31:32w] of sequence wr_seq, where w = wr_word, to wr_data at the clock edge. Word 7 holds the first 32 bits played, and its data bit 31 is played first.
- R11: At reset, sequence 0 has 1s at play offsets 0 and 2, sequence 1 at offsets 0, 1, 128 and 129, sequence 2 at offset 100, and sequence 3 at offset 16 (offset k is bit 255-k). All other bits are 0.
- R12: The trigger is hw_trig OR sw_trig in delay and pattern modes; sw_trig has no effect in transparent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_trig | input | 1 | Synchronous hardware trigger |
| sw_trig | input | 1 | Software trigger strobe |
| mode | input | 2 | 00 delay, 01 pattern, 1x transparent |
| delay_len_m1 | input | 8 | Delay length minus one |
| pat_en | input | 4 | Sequence enable mask for pattern mode |
| wr_en | input | 1 | Pattern word write strobe |
| wr_seq | input | 2 | Sequence index of the write |
| wr_word | input | 3 | Word index of the write |
| wr_data | input | 32 | Write data |
| trig_out | output | 1 | Front-end trigger line |
| hold_out | output | 1 | ADC hold strobe |

## Verification
The first pattern bit and the hold pulse are due in the cycle right after the edge that samples the trigger. The bench raises the trigger for one edge and checks bit k and the hold at the falling edge k cycles after that edge. Delay-mode output is due L cycles after the input cycle. The bench keeps a history of the triggers it drove, one entry per step, and compares each falling-edge sample against the entry L-1 steps back; each length change is followed by one flushing step. Transparent output is checked one time unit after the input changes, with no clock edge in between.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int NSEQ   = 4;
    localparam int PLEN   = 256;
    localparam int WW     = 32;
    localparam int DMAX   = 256;

    localparam int SEQ_RESET  = 0;
    localparam int SEQ_CAL    = 1;
    localparam int SEQ_SWTRIG = 2;
    localparam int SEQ_HWTRIG = 3;

    // play offsets (offset k is stored at bit PLEN-1-k)
    localparam int CAL_REPEAT_OFS = 128;
    localparam int SWTRIG_OFS     = 100;
    localparam int HWTRIG_OFS     = 16;

    // sequences that never produce front-end data
    localparam logic [NSEQ-1:0] QUIET_MASK = 4'b0011;

    typedef enum logic [1:0] {
        MODE_DELAY    = 2'b00,
        MODE_PATTERN  = 2'b01,
        MODE_THRU     = 2'b10,
        MODE_THRU_ALT = 2'b11
    } mode_e;

    function automatic logic [PLEN-1:0] default_seq(input int idx);
        logic [PLEN-1:0] v;
        v = '0;
        case (idx)
            SEQ_RESET: begin
                v[PLEN-1] = 1'b1;
                v[PLEN-3] = 1'b1;
            end
            SEQ_CAL: begin
                v[PLEN-1] = 1'b1;
                v[PLEN-2] = 1'b1;
                v[PLEN-1-CAL_REPEAT_OFS] = 1'b1;
                v[PLEN-2-CAL_REPEAT_OFS] = 1'b1;
            end
            SEQ_SWTRIG: v[PLEN-1-SWTRIG_OFS] = 1'b1;
            SEQ_HWTRIG: v[PLEN-1-HWTRIG_OFS] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/trig_seq_delay.sv
module trig_seq_delay #(
    parameter int DMAX = trig_seq_pkg::DMAX
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    din,
    input  logic [$clog2(DMAX)-1:0] len_m1,
    output logic                    dout
);
    localparam int LW = $clog2(DMAX);

    logic [DMAX-1:0] line_q;
    logic [LW-1:0]   len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            len_q  <= '0;
        end else begin
            len_q <= len_m1;
            if (len_m1 != len_q) begin
                line_q <= '0;
            end else begin
                line_q <= {line_q[DMAX-2:0], din};
            end
        end
    end

    assign dout = line_q[len_m1];

endmodule

// File: rtl/trig_seq_patmem.sv
module trig_seq_patmem #(
    parameter int NSEQ = trig_seq_pkg::NSEQ,
    parameter int PLEN = trig_seq_pkg::PLEN,
    parameter int WW   = trig_seq_pkg::WW
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [$clog2(NSEQ)-1:0]         wr_seq,
    input  logic [$clog2(PLEN/WW)-1:0]      wr_word,
    input  logic [WW-1:0]                   wr_data,
    output logic [NSEQ-1:0][PLEN-1:0]       mem
);
    localparam int SW = $clog2(NSEQ);

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        logic [PLEN-1:0] bits_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q <= trig_seq_pkg::default_seq(s);
            end else if (wr_en && wr_seq == SW'(s)) begin
                bits_q[int'(wr_word)*WW +: WW] <= wr_data;
            end
        end
        assign mem[s] = bits_q;
    end

endmodule

// File: rtl/trig_seq_player.sv
module trig_seq_player #(
    parameter int              NSEQ  = trig_seq_pkg::NSEQ,
    parameter int              PLEN  = trig_seq_pkg::PLEN,
    parameter logic [NSEQ-1:0] QUIET = trig_seq_pkg::QUIET_MASK
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_req,
    input  logic [NSEQ-1:0]           en_i,
    input  logic [NSEQ-1:0][PLEN-1:0] mem_i,
    output logic                      bit_o,
    output logic                      hold_o,
    output logic                      busy_o
);
    localparam int CW = $clog2(PLEN);

    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic [NSEQ-1:0] en;
    } play_t;

    play_t           st_q;
    logic            go;
    logic [CW-1:0]   rd_idx;
    logic [NSEQ-1:0] rd_en;
    logic            nxt_bit;

    assign go = start_req & ~st_q.busy;

    always_comb begin
        rd_idx  = go ? CW'(PLEN-1) : CW'(PLEN-1) - st_q.cnt;
        rd_en   = go ? en_i : st_q.en;
        nxt_bit = 1'b0;
        for (int s = 0; s < NSEQ; s++) begin
            nxt_bit = nxt_bit | (rd_en[s] & mem_i[s][rd_idx]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            bit_o  <= 1'b0;
            hold_o <= 1'b0;
        end else begin
            hold_o <= 1'b0;
            if (go) begin
                st_q.busy <= 1'b1;
                st_q.cnt  <= CW'(1);
                st_q.en   <= en_i;
                bit_o     <= nxt_bit;
                hold_o    <= |(en_i & ~QUIET);
            end else if (st_q.busy) begin
                bit_o    <= nxt_bit;
                st_q.cnt <= st_q.cnt + CW'(1);
                if (st_q.cnt == CW'(PLEN-1)) begin
                    st_q.busy <= 1'b0;
                end
            end else begin
                bit_o <= 1'b0;
            end
        end
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
    parameter int NSEQ = trig_seq_pkg::NSEQ,
    parameter int PLEN = trig_seq_pkg::PLEN,
    parameter int WW   = trig_seq_pkg::WW,
    parameter int DMAX = trig_seq_pkg::DMAX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hw_trig,
    input  logic                       sw_trig,
    input  logic [1:0]                 mode,
    input  logic [$clog2(DMAX)-1:0]    delay_len_m1,
    input  logic [NSEQ-1:0]            pat_en,
    input  logic                       wr_en,
    input  logic [$clog2(NSEQ)-1:0]    wr_seq,
    input  logic [$clog2(PLEN/WW)-1:0] wr_word,
    input  logic [WW-1:0]              wr_data,
    output logic                       trig_out,
    output logic                       hold_out
);
    import trig_seq_pkg::*;

    localparam logic [NSEQ-1:0] QUIET_MASK_L = QUIET_MASK;

    mode_e                     mode_q;
    logic                      any_trig;
    logic                      dly_out;
    logic                      pat_out;
    logic                      play_busy;
    logic [NSEQ-1:0][PLEN-1:0] mem;

    assign mode_q   = mode_e'(mode);
    assign any_trig = hw_trig | sw_trig;

    trig_seq_delay #(.DMAX(DMAX)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .din    (any_trig & (mode_q == MODE_DELAY)),
        .len_m1 (delay_len_m1),
        .dout   (dly_out)
    );

    trig_seq_patmem #(.NSEQ(NSEQ), .PLEN(PLEN), .WW(WW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_seq  (wr_seq),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .mem     (mem)
    );

    trig_seq_player #(.NSEQ(NSEQ), .PLEN(PLEN), .QUIET(QUIET_MASK_L)) u_play (
        .clk       (clk),
        .rst       (rst),
        .start_req (any_trig & (mode_q == MODE_PATTERN)),
        .en_i      (pat_en),
        .mem_i     (mem),
        .bit_o     (pat_out),
        .hold_o    (hold_out),
        .busy_o    (play_busy)
    );

    always_comb begin
        case (mode_q)
            MODE_DELAY:   trig_out = dly_out;
            MODE_PATTERN: trig_out = pat_out;
            default:      trig_out = hw_trig;
        endcase
    end

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int              NSEQ  = 4,
    parameter int              DW    = 8,
    parameter logic [NSEQ-1:0] QUIET = 4'b0011
) (
    input logic            clk,
    input logic            rst,
    input logic            hw_trig,
    input logic            sw_trig,
    input logic [1:0]      mode,
    input logic [DW-1:0]   delay_len_m1,
    input logic [NSEQ-1:0] pat_en,
    input logic            trig_out,
    input logic            hold_out,
    input logic            busy
);

    // R8
    hold_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        hold_out |=> !hold_out);

    // R7
    hold_needs_data_seq_chk: assert property (@(posedge clk) disable iff (rst)
        hold_out |-> (|($past(pat_en) & ~QUIET)) && $past(hw_trig || sw_trig));

    // R5
    hold_with_playback_chk: assert property (@(posedge clk) disable iff (rst)
        hold_out |-> busy);

    // R6
    busy_ignores_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (hw_trig || sw_trig)) |=> !hold_out);

    // R2
    delay_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && $past(mode) == 2'b00 && delay_len_m1 == '0
         && $past(delay_len_m1) == '0 && $past(delay_len_m1, 2) == '0
         && !$past(rst) && !$past(rst, 2) && $past(hw_trig || sw_trig))
        |-> trig_out);

    // R4
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !$past(rst) && !$past(rst, 2)
         && $past(delay_len_m1) != $past(delay_len_m1, 2))
        |-> !trig_out);

endmodule

bind trig_seq trig_seq_chk #(
    .NSEQ  (NSEQ),
    .DW    ($clog2(DMAX)),
    .QUIET (QUIET_MASK_L)
) u_trig_seq_chk (
    .clk          (clk),
    .rst          (rst),
    .hw_trig      (hw_trig),
    .sw_trig      (sw_trig),
    .mode         (mode),
    .delay_len_m1 (delay_len_m1),
    .pat_en       (pat_en),
    .trig_out     (trig_out),
    .hold_out     (hold_out),
    .busy         (play_busy)
);

// File: tb/trig_seq_bench.sv
module trig_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        hw_trig, sw_trig;
    logic [1:0]  mode;
    logic [7:0]  delay_len_m1;
    logic [3:0]  pat_en;
    logic        wr_en;
    logic [1:0]  wr_seq;
    logic [2:0]  wr_word;
    logic [31:0] wr_data;
    logic        trig_out, hold_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit [255:0] model [4];
    bit hist [1024];

    always #2 clk = ~clk;

    trig_seq u_trig_seq (
        .clk(clk), .rst(rst), .hw_trig(hw_trig), .sw_trig(sw_trig),
        .mode(mode), .delay_len_m1(delay_len_m1), .pat_en(pat_en),
        .wr_en(wr_en), .wr_seq(wr_seq), .wr_word(wr_word), .wr_data(wr_data),
        .trig_out(trig_out), .hold_out(hold_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit [255:0] dflt(input int s);
        bit [255:0] v = '0;
        case (s)
            0: begin v[255] = 1; v[253] = 1; end
            1: begin v[255] = 1; v[254] = 1; v[127] = 1; v[126] = 1; end
            2: v[255-100] = 1;
            default: v[255-16] = 1;
        endcase
        return v;
    endfunction

    function automatic bit exp_bit(input bit [3:0] en, input int k);
        bit b = 0;
        for (int s = 0; s < 4; s++) b |= en[s] & model[s][255-k];
        return b;
    endfunction

    task automatic write_word(input int s, input int w, input bit [31:0] d);
        wr_en = 1; wr_seq = 2'(s); wr_word = 3'(w); wr_data = d;
        step();
        wr_en = 0;
        model[s][w*32 +: 32] = d;
    endtask

    task automatic play(input bit [3:0] en, input bit noise, input bit use_sw);
        mode = 2'b01; pat_en = en;
        if (use_sw) sw_trig = 1; else hw_trig = 1;
        step();
        hw_trig = 0; sw_trig = 0;
        pat_en = ~en;   // captured value must be used (R5)
        for (int k = 0; k < 256; k++) begin
            check(trig_out == exp_bit(en, k), $sformatf("R5 bit k=%0d en=%b", k, en),
                  int'(trig_out), int'(exp_bit(en, k)));
            if (k == 0)
                check(hold_out == (en[2] | en[3]), $sformatf("R7 R8 hold start en=%b", en),
                      int'(hold_out), int'(en[2] | en[3]));
            else
                check(hold_out == 0, $sformatf("R6 R8 hold k=%0d", k), int'(hold_out), 0);
            if (noise && k < 255) begin
                hw_trig = ($urandom % 3) == 0;
                sw_trig = ($urandom % 3) == 0;
            end else begin
                hw_trig = 0; sw_trig = 0;
            end
            step();
        end
        hw_trig = 0; sw_trig = 0;
        check(trig_out == 0 && hold_out == 0, "R5 idle after playback", int'(trig_out), 0);
    endtask

    task automatic run_delay(input int len, input int n, input int density);
        mode = 2'b00;
        delay_len_m1 = 8'(len - 1);
        hw_trig = 0; sw_trig = 0;
        step();   // flushing step
        for (int i = 0; i < 1024; i++) hist[i] = 0;
        for (int i = 0; i < n + len; i++) begin
            bit t = (i < n) && (($urandom % density) == 0);
            hist[i] = t;
            if (t) begin
                if ($urandom % 2) hw_trig = 1; else sw_trig = 1;
            end
            step();
            hw_trig = 0; sw_trig = 0;
            begin
                bit e = (i - len + 1 >= 0) ? hist[i - len + 1] : 1'b0;
                check(trig_out == e, $sformatf("R2 R3 R12 delay L=%0d i=%0d", len, i),
                      int'(trig_out), int'(e));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; hw_trig = 0; sw_trig = 0; mode = 2'b01; delay_len_m1 = 0;
        pat_en = 4'b1111; wr_en = 0; wr_seq = 0; wr_word = 0; wr_data = 0;
        for (int s = 0; s < 4; s++) model[s] = dflt(s);
        repeat (3) step();
        check(trig_out == 0 && hold_out == 0, "R1 during reset", int'(trig_out), 0);
        rst = 0;
        step();
        check(trig_out == 0 && hold_out == 0, "R1 after reset", int'(trig_out), 0);

        // R11 default contents, R7 hold rule over default sets
        play(4'b0001, 0, 0);
        play(4'b0010, 0, 1);
        play(4'b0011, 0, 0);
        play(4'b0100, 0, 1);
        play(4'b1000, 0, 0);
        play(4'b1111, 1, 0);

        // R10 word addressing
        write_word(3, 7, 32'h8000_0001);
        write_word(0, 0, 32'h0000_0001);
        play(4'b1001, 0, 0);

        // random memory and enables, triggers during playback (R6)
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 4; j++)
                write_word($urandom % 4, $urandom % 8, $urandom);
            play(4'($urandom), 1, r[0]);
        end

        // R9 R12 transparent
        mode = 2'b10; hw_trig = 1; sw_trig = 0; #1;
        check(trig_out == 1, "R9 thru high", int'(trig_out), 1);
        hw_trig = 0; sw_trig = 1; #1;
        check(trig_out == 0, "R12 sw ignored in thru", int'(trig_out), 0);
        mode = 2'b11; hw_trig = 1; sw_trig = 0; #1;
        check(trig_out == 1, "R9 thru alt", int'(trig_out), 1);
        hw_trig = 0; #1;
        check(trig_out == 0, "R9 thru low", int'(trig_out), 0);
        step();

        // R2 R3 delay line
        run_delay(1, 40, 2);
        run_delay(2, 40, 1);
        run_delay(3, 60, 3);
        run_delay(256, 20, 4);
        for (int r = 0; r < 4; r++) run_delay(1 + ($urandom % 64), 80, 2 + r);

        // R4 flush on length change
        mode = 2'b00; delay_len_m1 = 8'd19; step();
        hw_trig = 1; step(); hw_trig = 0;
        repeat (5) step();
        delay_len_m1 = 8'd29; step();
        for (int i = 0; i < 40; i++) begin
            check(trig_out == 0, $sformatf("R4 flushed i=%0d", i), int'(trig_out), 0);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule